// File: doc/BRIEF.md
# Reset and Power-Mode Controller

This block sits beside a small 8-bit controller core. It decides when the core is held in reset, remembers which program memory the core fetches from, and runs the two low-power modes. A reset request arrives on an external pin. That request is honoured only after the pin has stayed high for two full machine cycles of twelve oscillator clocks each. While the core is held in reset, the block keeps sampling the external-access pin. The value it has when reset ends is kept until the next reset.

Software enters a low-power mode by writing the power-control register. The block then turns the mode into three enables: the core clock, the peripheral clock and the oscillator. It also produces override levels for the bus strobes and the two address ports. Idle stops only the core, and an enabled interrupt wakes it. Power-down stops everything, and only a qualified pin reset ends it.

Top module: `rpm_ctrl`

## Requirements
- R1: `core_rst` goes high only on the clock edge that samples `rst_pin` high for the 24th consecutive time (HOLD_MC=2 machine cycles of OSC_PER_MC=12 clocks). A shorter pulse leaves `core_rst` low.
- R2: `core_rst` falls on the first edge that samples `rst_pin` low. The synchronous power-on input `rst` also forces `core_rst` high.
- R3: On every edge where `core_rst` is high, `ext_prog` takes the inverse of `ea_pin`. Here 1 means external program memory. While `core_rst` is low, `ea_pin` has no effect.
- R4: Power-control register fields: bit 0 is the idle request, bit 1 is power-down, bits 3:2 are free flags and bit 7 is the baud-doubling flag. Bits 6:4 read 0. Any reset clears the register to 0x00, and writes are ignored while `core_rst` is high.
- R5: A write that sets bit 0 and bit 1 together stores power-down only: bit 1 is 1 and bit 0 is 0.
- R6: In idle, `cpu_clk_en`=0, `per_clk_en`=1 and `osc_en`=1. A high `irq_pending` clears bit 0 on the next edge, which returns the block to run mode.
- R7: In power-down, all three enables are 0 and `irq_pending` has no effect. Only `core_rst` ends the mode. A high `rst_pin` sets `osc_en` from the next edge on.
- R8: While idle or power-down is active, register writes are ignored. In run mode, a write with `pcr_wr` high is stored on that edge.
- R9: `strobe_ovr` is 1 in both low-power modes. `strobe_lvl` is 1 in idle and 0 in power-down. In run mode both are 0.
- R10: `lo_port_float` = `ext_prog` AND (idle OR power-down). `hi_port_addr` = `ext_prog` AND idle. A 0 on `hi_port_addr` means the port drives its data latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous power-on reset, active high |
| rst_pin | input | 1 | External reset request pin |
| ea_pin | input | 1 | External-access pin, low selects external program memory |
| pcr_wr | input | 1 | Power-control register write strobe |
| pcr_wdata | input | 8 | Power-control register write data |
| irq_pending | input | 1 | An enabled interrupt is pending |
| core_rst | output | 1 | Qualified reset to the core |
| ext_prog | output | 1 | Latched external program memory select |
| pcr_q | output | 8 | Power-control register contents |
| cpu_clk_en | output | 1 | Core clock gate enable |
| per_clk_en | output | 1 | Peripheral clock gate enable |
| osc_en | output | 1 | Oscillator enable |
| strobe_ovr | output | 1 | Override the address-latch and program-store strobes |
| strobe_lvl | output | 1 | Forced level for both strobes |
| lo_port_float | output | 1 | Float the low address/data port |
| hi_port_addr | output | 1 | High port keeps driving the address byte |

## Verification
A wrong reset-count state shows up as `core_rst` rising one or more edges too early or too late. The bench sweeps the pulse length from 1 to 30 clocks and checks the output after every edge, so this is caught at the exact edge. A wrong mode state appears on the clock enables and pin overrides in the same cycle the register changes. Every one of the 256 write values is applied for both program-memory selections, and the bench checks all outputs right after each write. Exits that fail to happen, or happen when they should not, show up within one edge of the interrupt or reset stimulus.

// File: rtl/rpm_pkg.sv
package rpm_pkg;
  typedef enum logic [1:0] {
    MODE_RUN   = 2'd0,
    MODE_IDLE  = 2'd1,
    MODE_PDOWN = 2'd2
  } mode_e;

  localparam int          IDL_BIT  = 0;
  localparam int          PD_BIT   = 1;
  localparam logic [7:0]  REG_MASK = 8'h8F;
endpackage

// File: rtl/rpm_rst_qual.sv
module rpm_rst_qual #(
  parameter int HOLD = 24
) (
  input  logic clk,
  input  logic rst,
  input  logic rst_pin,
  output logic core_rst
);
  localparam int CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] TOP = CW'(HOLD - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      core_rst <= 1'b1;
    end else begin
      if (!rst_pin)        cnt <= '0;
      else if (cnt != TOP) cnt <= cnt + 1'b1;
      core_rst <= rst_pin && (cnt == TOP);
    end
  end

  AST_RISE_AFTER_HOLD: assert property (@(posedge clk) disable iff (rst)
    $rose(core_rst) |-> (cnt == TOP)); // R1
  AST_PIN_LOW_DROPS: assert property (@(posedge clk) disable iff (rst)
    !rst_pin |=> !core_rst); // R2
endmodule

// File: rtl/rpm_mode_reg.sv
module rpm_mode_reg
  import rpm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       core_rst,
  input  logic       wr,
  input  logic [7:0] wdata,
  input  logic       irq,
  output logic [7:0] pcr,
  output mode_e      mode
);
  logic [7:0] wval;

  always_comb begin
    wval = wdata & REG_MASK;
    if (wval[PD_BIT]) wval[IDL_BIT] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst || core_rst) begin
      pcr <= '0;
    end else if (pcr[PD_BIT]) begin
      pcr <= pcr;
    end else if (pcr[IDL_BIT]) begin
      if (irq) pcr[IDL_BIT] <= 1'b0;
    end else if (wr) begin
      pcr <= wval;
    end
  end

  always_comb begin
    if (pcr[PD_BIT])       mode = MODE_PDOWN;
    else if (pcr[IDL_BIT]) mode = MODE_IDLE;
    else                   mode = MODE_RUN;
  end

  AST_PD_OVER_IDLE: assert property (@(posedge clk) disable iff (rst)
    !(pcr[IDL_BIT] && pcr[PD_BIT])); // R5
  AST_PD_STICKY: assert property (@(posedge clk) disable iff (rst)
    (pcr[PD_BIT] && !core_rst) |=> pcr[PD_BIT]); // R7
  AST_IDLE_WAKE: assert property (@(posedge clk) disable iff (rst)
    (pcr[IDL_BIT] && irq && !core_rst) |=> !pcr[IDL_BIT]); // R6
  AST_LP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    ((pcr[IDL_BIT] || pcr[PD_BIT]) && wr && !irq && !core_rst) |=> $stable(pcr)); // R8
  AST_RST_CLEARS: assert property (@(posedge clk) disable iff (rst)
    core_rst |=> (pcr == 8'h00)); // R4
endmodule

// File: rtl/rpm_pin_ovr.sv
module rpm_pin_ovr
  import rpm_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  mode_e mode,
  input  logic  ext,
  input  logic  rst_pin,
  output logic  cpu_clk_en,
  output logic  per_clk_en,
  output logic  osc_en,
  output logic  strobe_ovr,
  output logic  strobe_lvl,
  output logic  lo_float,
  output logic  hi_addr
);
  logic wake_q;
  logic idle, pd, lp;

  always_ff @(posedge clk) begin
    if (rst) wake_q <= 1'b0;
    else     wake_q <= (mode == MODE_PDOWN) && rst_pin;
  end

  always_comb begin
    idle       = (mode == MODE_IDLE);
    pd         = (mode == MODE_PDOWN);
    lp         = idle || pd;
    cpu_clk_en = !lp;
    per_clk_en = !pd;
    osc_en     = !pd || wake_q;
    strobe_ovr = lp;
    strobe_lvl = idle;
    lo_float   = lp && ext;
    hi_addr    = idle && ext;
  end

  AST_OSC_WAKE: assert property (@(posedge clk) disable iff (rst)
    ((mode == MODE_PDOWN) && rst_pin) |=> osc_en); // R7
endmodule

// File: rtl/rpm_ctrl.sv
module rpm_ctrl #(
  parameter int OSC_PER_MC = 12,
  parameter int HOLD_MC    = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rst_pin,
  input  logic       ea_pin,
  input  logic       pcr_wr,
  input  logic [7:0] pcr_wdata,
  input  logic       irq_pending,
  output logic       core_rst,
  output logic       ext_prog,
  output logic [7:0] pcr_q,
  output logic       cpu_clk_en,
  output logic       per_clk_en,
  output logic       osc_en,
  output logic       strobe_ovr,
  output logic       strobe_lvl,
  output logic       lo_port_float,
  output logic       hi_port_addr
);
  import rpm_pkg::*;

  localparam int HOLD = OSC_PER_MC * HOLD_MC;

  mode_e mode;

  rpm_rst_qual #(.HOLD(HOLD)) u_qual (
    .clk      (clk),
    .rst      (rst),
    .rst_pin  (rst_pin),
    .core_rst (core_rst)
  );

  always_ff @(posedge clk) begin
    if (rst || core_rst) ext_prog <= ~ea_pin;
  end

  AST_EA_IGNORED: assert property (@(posedge clk) disable iff (rst)
    !core_rst |=> $stable(ext_prog)); // R3

  rpm_mode_reg u_reg (
    .clk      (clk),
    .rst      (rst),
    .core_rst (core_rst),
    .wr       (pcr_wr),
    .wdata    (pcr_wdata),
    .irq      (irq_pending),
    .pcr      (pcr_q),
    .mode     (mode)
  );

  rpm_pin_ovr u_pins (
    .clk        (clk),
    .rst        (rst),
    .mode       (mode),
    .ext        (ext_prog),
    .rst_pin    (rst_pin),
    .cpu_clk_en (cpu_clk_en),
    .per_clk_en (per_clk_en),
    .osc_en     (osc_en),
    .strobe_ovr (strobe_ovr),
    .strobe_lvl (strobe_lvl),
    .lo_float   (lo_port_float),
    .hi_addr    (hi_port_addr)
  );
endmodule

// File: tb/rpm_ctrl_bench.sv
module rpm_ctrl_bench;
  logic clk = 1'b0;
  logic rst, rst_pin, ea_pin, pcr_wr, irq_pending;
  logic [7:0] pcr_wdata;
  logic core_rst, ext_prog, cpu_clk_en, per_clk_en, osc_en;
  logic strobe_ovr, strobe_lvl, lo_port_float, hi_port_addr;
  logic [7:0] pcr_q;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  rpm_ctrl u_rpm_ctrl (
    .clk(clk), .rst(rst), .rst_pin(rst_pin), .ea_pin(ea_pin),
    .pcr_wr(pcr_wr), .pcr_wdata(pcr_wdata), .irq_pending(irq_pending),
    .core_rst(core_rst), .ext_prog(ext_prog), .pcr_q(pcr_q),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_en(osc_en),
    .strobe_ovr(strobe_ovr), .strobe_lvl(strobe_lvl),
    .lo_port_float(lo_port_float), .hi_port_addr(hi_port_addr)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] d);
    pcr_wr = 1'b1;
    pcr_wdata = d;
    tick();
    pcr_wr = 1'b0;
  endtask

  task automatic pin_reset(input logic ea_val);
    ea_pin = ea_val;
    rst_pin = 1'b1;
    repeat (24) tick();
    rst_pin = 1'b0;
    tick();
  endtask

  task automatic chk_outs(input logic idle, input logic pd, input logic ext);
    chk({7'd0, cpu_clk_en}, {7'd0, !(idle || pd)}, "R6 cpu_clk_en");
    chk({7'd0, per_clk_en}, {7'd0, !pd}, "R7 per_clk_en");
    chk({7'd0, osc_en}, {7'd0, !pd}, "R7 osc_en");
    chk({7'd0, strobe_ovr}, {7'd0, idle || pd}, "R9 strobe_ovr");
    chk({7'd0, strobe_lvl}, {7'd0, idle}, "R9 strobe_lvl");
    chk({7'd0, lo_port_float}, {7'd0, (idle || pd) && ext}, "R10 lo_port_float");
    chk({7'd0, hi_port_addr}, {7'd0, idle && ext}, "R10 hi_port_addr");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic ext_exp;
    rst = 1'b1; rst_pin = 1'b0; ea_pin = 1'b1; pcr_wr = 1'b0;
    pcr_wdata = 8'h00; irq_pending = 1'b0;
    repeat (3) tick();
    chk({7'd0, core_rst}, 8'd1, "R2 power-on core_rst");
    chk(pcr_q, 8'h00, "R4 reset value");
    rst = 1'b0;
    tick();
    chk({7'd0, core_rst}, 8'd0, "R2 release with pin low");
    chk({7'd0, ext_prog}, 8'd0, "R3 ea high selects internal");
    ext_exp = 1'b0;

    // R1/R2/R3/R4: pulse length sweep
    for (int len = 1; len <= 30; len++) begin
      wr_reg(8'h84);
      ea_pin = len[0];
      rst_pin = 1'b1;
      for (int i = 1; i <= len; i++) begin
        tick();
        chk({7'd0, core_rst}, {7'd0, i >= 24}, "R1 qualified reset timing");
      end
      rst_pin = 1'b0;
      tick();
      chk({7'd0, core_rst}, 8'd0, "R2 drop on pin low");
      if (len >= 24) ext_exp = ~len[0];
      chk(pcr_q, (len >= 24) ? 8'h00 : 8'h84, "R4 register after pulse");
      ea_pin = ~ea_pin;
      tick();
      chk({7'd0, ext_prog}, {7'd0, ext_exp}, "R3 latched access select");
    end

    // R4..R10: every write value under both program-memory selections
    for (int e = 0; e <= 1; e++) begin
      pin_reset(e == 0);
      chk({7'd0, ext_prog}, e[7:0], "R3 select after reset");
      for (int d = 0; d < 256; d++) begin
        logic [7:0] exp;
        logic idle, pd;
        exp = d[7:0] & 8'h8F;
        if (exp[1]) exp[0] = 1'b0;
        idle = exp[0];
        pd = exp[1];
        wr_reg(d[7:0]);
        chk(pcr_q, exp, (d[1:0] == 2'b11) ? "R5 power-down priority" : "R4 R8 write in run");
        chk_outs(idle, pd, e[0]);
        if (idle) begin
          wr_reg(8'h02);
          chk(pcr_q, exp, "R8 write ignored in idle");
          irq_pending = 1'b1;
          tick();
          irq_pending = 1'b0;
          chk(pcr_q, exp & 8'hFE, "R6 interrupt ends idle");
          chk_outs(1'b0, 1'b0, e[0]);
        end
        if (pd) begin
          wr_reg(8'h00);
          chk(pcr_q, exp, "R8 write ignored in power-down");
          irq_pending = 1'b1;
          tick();
          irq_pending = 1'b0;
          chk(pcr_q, exp, "R7 interrupt no effect in power-down");
          chk_outs(1'b0, 1'b1, e[0]);
          ea_pin = (e == 0);
          rst_pin = 1'b1;
          tick();
          chk({7'd0, osc_en}, 8'd1, "R7 pin wakes oscillator");
          repeat (23) tick();
          rst_pin = 1'b0;
          tick();
          chk(pcr_q, 8'h00, "R7 reset ends power-down");
          chk_outs(1'b0, 1'b0, e[0]);
        end
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule